// File: doc/BRIEF.md
# Prioritised Interrupt Pending Controller

This block sits beside a small CPU core and gathers interrupt requests from the on-chip sources: GPIO, timers, the two-wire serial unit, the hub and the USB endpoints. A request pulse on a source line sets that source's pending latch. The latch stays set until the CPU takes the interrupt or the block is reset. Each source also has an enable bit, and the CPU rewrites all the enable bits in one write. A global enable sits over the whole set. The CPU's enable-interrupts instruction and its return-from-interrupt instruction both set the global enable, and the disable-interrupts instruction clears it.

The interrupt is offered to the CPU over a valid/ready pair. Valid is high when the global enable is set and at least one source is both pending and enabled. While valid is high, the vector output carries the entry address of the winning source. Address zero is the reset entry. Source i has its entry at 2*(i+1), because every entry holds a two-byte jump. Ready acts only when valid is high. Holding ready low is the CPU's form of back-pressure: nothing is consumed and nothing is lost. The vector is not held stable while the CPU waits. If a source with a lower index becomes pending and enabled, the vector moves to that source, and the CPU uses the value present in the cycle it accepts. When the CPU accepts, the block clears the winner's pending latch and the global enable. The handler then ends with a return that sets the global enable again.

Top module: `pend_irq_ctrl`

## Requirements
- R1: After reset, all pending latches, all enable bits and the global enable are clear, so both `irq_valid_o` and `irq_pending_o` are low.
- R2: A high bit on `irq_req_i` sets that source's pending latch at the next clock edge. From that edge on, `irq_pending_o` is high whether or not the source is enabled.
- R3: A pending latch keeps its value while enable bits or the global enable change. Only an accept of that source, or reset, clears it.
- R4: When `en_wr_i` is high, `en_wdata_i` replaces the whole enable register at the next edge. A 1 in bit i enables source i.
- R5: `irq_valid_o` is high exactly when the global enable is set and some source is both pending and enabled.
- R6: While `irq_valid_o` is high, `irq_vector_o` equals 2*(i+1), where i is the lowest-numbered source that is pending and enabled. Source 0 (USB bus reset) therefore maps to 0x0002, and source 1 (the 128-µs timer) maps to 0x0004.
- R7: An accept is a cycle in which `irq_valid_o` and `irq_ready_i` are both high. It clears the selected source's pending latch and the global enable at the next edge. All other pending latches are left untouched.
- R8: If a request for a source arrives in the same cycle as the accept that clears it, that source stays pending.
- R9: `ei_i` or `reti_i` sets the global enable and `di_i` clears it. When set and clear arrive together, clear wins, and an accept counts as a clear.
- R10: `irq_ready_i` has no effect while `irq_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req_i | input | N | Request pulses, one per source |
| en_wr_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | N | New value for the enable register |
| ei_i | input | 1 | Enable-interrupts instruction executed |
| di_i | input | 1 | Disable-interrupts instruction executed |
| reti_i | input | 1 | Return-from-interrupt executed |
| irq_valid_o | output | 1 | An interrupt is offered to the CPU |
| irq_ready_i | input | 1 | CPU takes the offered interrupt |
| irq_vector_o | output | ADDR_W | Entry address of the offered interrupt |
| irq_pending_o | output | 1 | At least one pending latch is set |

## Verification
A lost or stuck pending latch shows up within one cycle, in either of two ways. `irq_pending_o` has the wrong level, or the next vector offered after a re-enable is wrong. Draining all sources one accept at a time exposes every latch in priority order. A global enable that is not cleared on accept shows as `irq_valid_o` still high in the cycle after the accept. A wrong priority decode shows on `irq_vector_o` at once. For that reason every combination of pending and enable patterns for a five-source configuration is compared against the lowest-index rule.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  // spacing between entry addresses: each holds a two-byte jump
  localparam int VEC_STRIDE = 2;

  // set/clear command for the global enable
  typedef struct packed {
    logic set;
    logic clr;
  } gie_cmd_t;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_latch
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n)        q <= 1'b0;
      else if (req_i[g]) q <= 1'b1;   // a new request beats a same-cycle clear
      else if (clr_i[g]) q <= 1'b0;
    end
    assign pend_o[g] = q;
  end
endmodule

// File: rtl/irq_mask_gate.sv
module irq_mask_gate
  import irq_ctl_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_wr_i,
  input  logic [N-1:0] en_wdata_i,
  input  gie_cmd_t     gie_cmd_i,
  input  logic [N-1:0] pend_i,
  output logic [N-1:0] act_o,
  output logic         gie_o
);
  logic [N-1:0] en_q;
  logic         gie_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       en_q <= '0;
    else if (en_wr_i) en_q <= en_wdata_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              gie_q <= 1'b0;
    else if (gie_cmd_i.clr)  gie_q <= 1'b0;
    else if (gie_cmd_i.set)  gie_q <= 1'b1;
  end

  assign act_o = pend_i & en_q;
  assign gie_o = gie_q;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_ctl_pkg::*;
#(
  parameter int N      = 8,
  parameter int ADDR_W = 14
) (
  input  logic [N-1:0]      act_i,
  output logic              any_o,
  output logic [N-1:0]      onehot_o,
  output logic [ADDR_W-1:0] vec_o
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [IDX_W-1:0] idx;

  // scan downward so the lowest active index is the last one written
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act_i[i]) idx = IDX_W'(i);
    end
  end

  assign any_o    = |act_i;
  assign onehot_o = any_o ? (N'(1) << idx) : '0;
  assign vec_o    = ADDR_W'((32'(idx) + 32'd1) * 32'(VEC_STRIDE));
endmodule

// File: rtl/pend_irq_ctrl.sv
module pend_irq_ctrl
  import irq_ctl_pkg::*;
#(
  parameter int N      = 8,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_req_i,
  input  logic              en_wr_i,
  input  logic [N-1:0]      en_wdata_i,
  input  logic              ei_i,
  input  logic              di_i,
  input  logic              reti_i,
  output logic              irq_valid_o,
  input  logic              irq_ready_i,
  output logic [ADDR_W-1:0] irq_vector_o,
  output logic              irq_pending_o
);
  logic [N-1:0] pend, act, win, clr;
  logic         any_act, gie, accept;
  gie_cmd_t     cmd;

  assign accept  = irq_valid_o & irq_ready_i;
  assign clr     = win & {N{accept}};
  assign cmd.set = ei_i | reti_i;
  assign cmd.clr = di_i | accept;

  irq_pend_bank #(.N(N)) bank_i (
    .clk(clk), .rst_n(rst_n), .req_i(irq_req_i), .clr_i(clr), .pend_o(pend)
  );

  irq_mask_gate #(.N(N)) gate_i (
    .clk(clk), .rst_n(rst_n), .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
    .gie_cmd_i(cmd), .pend_i(pend), .act_o(act), .gie_o(gie)
  );

  irq_prio_sel #(.N(N), .ADDR_W(ADDR_W)) sel_i (
    .act_i(act), .any_o(any_act), .onehot_o(win), .vec_o(irq_vector_o)
  );

  assign irq_valid_o   = gie & any_act;
  assign irq_pending_o = |pend;
endmodule

// File: rtl/pend_irq_ctrl_chk.sv
module pend_irq_ctrl_chk #(
  parameter int N      = 8,
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      irq_req_i,
  input logic              en_wr_i,
  input logic              ei_i,
  input logic              di_i,
  input logic              reti_i,
  input logic              irq_valid_o,
  input logic              irq_ready_i,
  input logic [ADDR_W-1:0] irq_vector_o,
  input logic              irq_pending_o
);
  assert_req_flags_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_i != '0) |=> irq_pending_o);

  assert_valid_needs_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> irq_pending_o);

  assert_vector_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> (irq_vector_o[0] == 1'b0 && irq_vector_o != '0
                     && irq_vector_o <= ADDR_W'(2 * N)));

  assert_accept_drops_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && irq_ready_i) |=> !irq_valid_o);

  assert_di_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    di_i |=> !irq_valid_o);

  assert_idle_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_valid_o && irq_ready_i && irq_req_i == '0 && !en_wr_i
     && !ei_i && !di_i && !reti_i) |=> ($stable(irq_pending_o) && !irq_valid_o));
endmodule

bind pend_irq_ctrl pend_irq_ctrl_chk #(.N(N), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req_i), .en_wr_i(en_wr_i),
  .ei_i(ei_i), .di_i(di_i), .reti_i(reti_i), .irq_valid_o(irq_valid_o),
  .irq_ready_i(irq_ready_i), .irq_vector_o(irq_vector_o),
  .irq_pending_o(irq_pending_o)
);

// File: tb/pend_irq_ctrl_tb_top.sv
module pend_irq_ctrl_tb_top;
  localparam int N  = 5;
  localparam int AW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0, en_wd = '0;
  logic          en_wr = 1'b0, ei = 1'b0, di = 1'b0, reti = 1'b0, ready = 1'b0;
  logic          valid, pnd;
  logic [AW-1:0] vec;

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  pend_irq_ctrl #(.N(N), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req_i(req), .en_wr_i(en_wr), .en_wdata_i(en_wd),
    .ei_i(ei), .di_i(di), .reti_i(reti), .irq_valid_o(valid), .irq_ready_i(ready),
    .irq_vector_o(vec), .irq_pending_o(pnd)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    req = '0; en_wr = 1'b0; en_wd = '0; ei = 1'b0; di = 1'b0; reti = 1'b0; ready = 1'b0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    cyc(); cyc();
    rst_n = 1'b1;
  endtask

  function automatic int exp_vec(int act);
    for (int i = 0; i < N; i++) if (act[i]) return (i + 1) * 2;
    return 0;
  endfunction

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 valid after reset", int'(valid), 0);
    chk("R1 pending after reset", int'(pnd), 0);

    // sweep of every pending pattern against every enable pattern
    for (int p = 0; p < (1 << N); p++) begin
      for (int e = 0; e < (1 << N); e++) begin
        do_reset();
        en_wr = 1'b1; en_wd = N'(e); req = N'(p);
        cyc(); idle();
        chk("R1 global enable clear before EI", int'(valid), 0);
        chk("R2 pending flag", int'(pnd), int'(p != 0));
        ei = 1'b1;
        cyc(); idle();
        chk("R5 valid", int'(valid), int'((p & e) != 0));
        if ((p & e) != 0) chk("R6 vector", int'(vec), exp_vec(p & e));
      end
    end

    // drain all sources in priority order
    do_reset();
    en_wr = 1'b1; en_wd = '1; req = '1;
    cyc(); idle();
    for (int k = 0; k < N; k++) begin
      ei = 1'b1; cyc(); idle();
      chk("R6 drain vector", int'(vec), (k + 1) * 2);
      chk("R5 drain valid", int'(valid), 1);
      ready = 1'b1; cyc(); idle();
      chk("R7 valid drops after accept", int'(valid), 0);
    end
    chk("R7 all latches cleared", int'(pnd), 0);

    // request in the same cycle as its clear
    do_reset();
    en_wr = 1'b1; en_wd = '1; req = N'(5'b00100);
    cyc(); idle();
    ei = 1'b1; cyc(); idle();
    chk("R6 vector bit2", int'(vec), 6);
    ready = 1'b1; req = N'(5'b00100); cyc(); idle();
    chk("R7 valid after accept", int'(valid), 0);
    chk("R8 still pending", int'(pnd), 1);
    ei = 1'b1; cyc(); idle();
    chk("R8 re-offered vector", int'(vec), 6);

    // global enable set/clear ordering
    di = 1'b1; ei = 1'b1; cyc(); idle();
    chk("R9 clear beats set", int'(valid), 0);
    reti = 1'b1; cyc(); idle();
    chk("R9 return sets enable", int'(valid), 1);
    ready = 1'b1; ei = 1'b1; cyc(); idle();
    chk("R9 accept beats EI", int'(valid), 0);
    chk("R7 latch cleared", int'(pnd), 0);

    // enable writes do not disturb pending
    do_reset();
    req = N'(5'b00010); cyc(); idle();
    ei = 1'b1; cyc(); idle();
    chk("R2 pending while disabled", int'(pnd), 1);
    chk("R4 disabled source not offered", int'(valid), 0);
    en_wr = 1'b1; en_wd = N'(5'b00010); cyc(); idle();
    chk("R4 enabled source offered", int'(valid), 1);
    chk("R6 timer vector", int'(vec), 4);
    en_wr = 1'b1; en_wd = '0; cyc(); idle();
    chk("R3 masked valid", int'(valid), 0);
    chk("R3 pending kept", int'(pnd), 1);
    ready = 1'b1; cyc(); idle();
    en_wr = 1'b1; en_wd = N'(5'b00010); cyc(); idle();
    chk("R10 ready ignored, still offered", int'(valid), 1);
    chk("R10 vector unchanged", int'(vec), 4);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule